// File: doc/BRIEF.md
# Rotating Byte-Lane Write Array

This block is a bank of byte-wide storage slots arranged as a ring. On every clock edge it can take a wide input word split into byte lanes, together with a per-lane enable mask and a starting slot number. Each enabled lane lands in the slot that lies as many places after the starting slot as the lane's own index. The slot number wraps modulo the number of slots, so a burst that starts near the top of the ring continues from slot 0.

The enable mask has no restriction. Any mix of lanes, all lanes, or none may be written in the same cycle. Lanes always map to distinct consecutive slots, so two lanes never compete for one slot and no priority rule is needed. Internally the mask is barrel-rotated into a per-slot strobe. The lane bytes are rotated the same way, so each slot is offered the byte aimed at it. The full contents of the ring are driven out in parallel at all times.

Default sizing is 64 slots of 8 bits and 16 lanes. The slot count must be a power of two and no smaller than the lane count.

Top module: `byte_ring_writer`

## Requirements
- R1: While `rst` is high at a rising edge, every slot becomes zero. The cleared contents appear on `slots_q` after that edge.
- R2: With `lane_en[i]` high, lane byte `lane_data[8i+7:8i]` is stored in slot `(wr_off + i) mod 64` at the rising edge. It is visible on `slots_q` from that edge on.
- R3: A write whose slot index passes 63 wraps to slot 0. For example, offset 60 with lane 5 enabled stores lane 5 in slot 1.
- R4: Any mask pattern writes every enabled lane in the same cycle. This includes several lanes and all 16 lanes.
- R5: A slot that no enabled lane targets in a cycle keeps its previous value. This covers slots inside the window whose lane bit is clear and slots outside the 16-slot window.
- R6: An all-zero `lane_en` leaves the whole array unchanged, whatever `wr_off` and `lane_data` are.
- R7: Slot s is always visible on `slots_q[8s+7:8s]`. No read selection is needed.
- R8: Reset takes precedence over writes. An edge with `rst` high and lanes enabled still leaves all slots zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, clears all slots |
| wr_off | input | 6 | Slot that lane 0 targets |
| lane_en | input | 16 | Per-lane write enable, any pattern |
| lane_data | input | 128 | Lane bytes, lane i at bits 8i+7:8i |
| slots_q | output | 512 | Contents of all slots, slot s at bits 8s+7:8s |

## Verification
The assertions assume that the inputs are stable and known at each rising edge. They also assume that reset is asserted for the first edge, so that a valid previous cycle exists before any history is compared. The bench drives all inputs on the falling edge. It holds reset over the first edges. After that it mixes directed offsets, including ones that wrap, with random offsets, masks and data, so the known-input assumption always holds.

// File: rtl/byte_ring_pkg.sv
package byte_ring_pkg;
    parameter int RING_SLOTS = 64;
    parameter int RING_LANES = 16;
    parameter int RING_BYTE  = 8;
endpackage

// File: rtl/ring_rotl.sv
// Logarithmic barrel rotation of a vector of equal elements, towards higher indices.
module ring_rotl #(
    parameter int ELEMS  = 64,
    parameter int ELEM_W = 8,
    localparam int AMT_W = $clog2(ELEMS),
    localparam int TOT_W = ELEMS * ELEM_W
) (
    input  logic [TOT_W-1:0] vec_i,
    input  logic [AMT_W-1:0] amt_i,
    output logic [TOT_W-1:0] vec_o
);
    logic [TOT_W-1:0] stage [0:AMT_W];

    assign stage[0] = vec_i;

    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        localparam int SH = (1 << k) * ELEM_W;
        assign stage[k+1] = amt_i[k]
            ? {stage[k][TOT_W-SH-1:0], stage[k][TOT_W-1:TOT_W-SH]}
            : stage[k];
    end

    assign vec_o = stage[AMT_W];
endmodule

// File: rtl/ring_slot_bank.sv
// Storage: each slot loads its offered byte when its strobe is high.
module ring_slot_bank #(
    parameter int SLOTS  = 64,
    parameter int BYTE_W = 8,
    localparam int TOT_W = SLOTS * BYTE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SLOTS-1:0] strobe_i,
    input  logic [TOT_W-1:0] bytes_i,
    output logic [TOT_W-1:0] bank_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
        end else begin
            for (int s = 0; s < SLOTS; s++) begin
                if (strobe_i[s]) begin
                    bank_q[s*BYTE_W +: BYTE_W] <= bytes_i[s*BYTE_W +: BYTE_W];
                end
            end
        end
    end
endmodule

// File: rtl/byte_ring_writer.sv
module byte_ring_writer
    import byte_ring_pkg::*;
#(
    parameter int SLOTS  = RING_SLOTS,
    parameter int LANES  = RING_LANES,
    parameter int BYTE_W = RING_BYTE,
    localparam int OFF_W = $clog2(SLOTS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [OFF_W-1:0]        wr_off,
    input  logic [LANES-1:0]        lane_en,
    input  logic [LANES*BYTE_W-1:0] lane_data,
    output logic [SLOTS*BYTE_W-1:0] slots_q
);
    localparam int PAD = SLOTS - LANES;

    logic [SLOTS-1:0]        mask_wide;
    logic [SLOTS-1:0]        slot_strobe;
    logic [SLOTS*BYTE_W-1:0] data_wide;
    logic [SLOTS*BYTE_W-1:0] slot_bytes;

    if (PAD > 0) begin : g_pad
        assign mask_wide = {{PAD{1'b0}}, lane_en};
        assign data_wide = {{(PAD*BYTE_W){1'b0}}, lane_data};
    end else begin : g_nopad
        assign mask_wide = lane_en;
        assign data_wide = lane_data;
    end

    ring_rotl #(.ELEMS(SLOTS), .ELEM_W(1)) strobe_rot_i (
        .vec_i(mask_wide),
        .amt_i(wr_off),
        .vec_o(slot_strobe)
    );

    ring_rotl #(.ELEMS(SLOTS), .ELEM_W(BYTE_W)) data_rot_i (
        .vec_i(data_wide),
        .amt_i(wr_off),
        .vec_o(slot_bytes)
    );

    ring_slot_bank #(.SLOTS(SLOTS), .BYTE_W(BYTE_W)) bank_i (
        .clk(clk),
        .rst(rst),
        .strobe_i(slot_strobe),
        .bytes_i(slot_bytes),
        .bank_q(slots_q)
    );
endmodule

// File: rtl/byte_ring_writer_chk.sv
module byte_ring_writer_chk #(
    parameter int SLOTS  = 64,
    parameter int LANES  = 16,
    parameter int BYTE_W = 8,
    localparam int OFF_W = $clog2(SLOTS)
) (
    input logic                    clk,
    input logic                    rst,
    input logic [OFF_W-1:0]        wr_off,
    input logic                    en_first,
    input logic                    en_last,
    input logic [LANES-1:0]        en_all,
    input logic [BYTE_W-1:0]       byte_first,
    input logic [BYTE_W-1:0]       byte_last,
    input logic [SLOTS*BYTE_W-1:0] slots_q
);
    logic                    prev_ok;
    logic                    prev_rst;
    logic [OFF_W-1:0]        prev_off;
    logic                    prev_en_first;
    logic                    prev_en_last;
    logic                    prev_idle;
    logic [BYTE_W-1:0]       prev_byte_first;
    logic [BYTE_W-1:0]       prev_byte_last;
    logic [SLOTS*BYTE_W-1:0] prev_q;
    logic [OFF_W-1:0]        idx_last;
    logic [OFF_W-1:0]        idx_far;

    always_ff @(posedge clk) begin
        prev_rst        <= rst;
        prev_ok         <= !rst;
        prev_off        <= wr_off;
        prev_en_first   <= en_first;
        prev_en_last    <= en_last;
        prev_idle       <= (en_all == '0);
        prev_byte_first <= byte_first;
        prev_byte_last  <= byte_last;
        prev_q          <= slots_q;
    end

    assign idx_last = prev_off + OFF_W'(LANES - 1);
    assign idx_far  = prev_off + OFF_W'(LANES % SLOTS);

    // R1 / R8: an edge taken in reset leaves every slot cleared
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        prev_rst |-> slots_q == '0);

    // R2: lane 0 lands at the offset slot
    p_first_lane_r2: assert property (@(posedge clk) disable iff (rst)
        (prev_ok && prev_en_first) |->
            slots_q[prev_off*BYTE_W +: BYTE_W] == prev_byte_first);

    // R3: last lane lands at offset plus lane count minus one, modulo ring size
    p_last_lane_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (prev_ok && prev_en_last) |->
            slots_q[idx_last*BYTE_W +: BYTE_W] == prev_byte_last);

    // R6: an empty mask changes nothing
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (prev_ok && prev_idle) |-> slots_q == prev_q);

    // R5: the slot just past the lane window is never touched
    if (LANES < SLOTS) begin : g_far
        p_outside_hold_r5: assert property (@(posedge clk) disable iff (rst)
            prev_ok |->
                slots_q[idx_far*BYTE_W +: BYTE_W] == prev_q[idx_far*BYTE_W +: BYTE_W]);
    end
endmodule

bind byte_ring_writer byte_ring_writer_chk #(
    .SLOTS(SLOTS), .LANES(LANES), .BYTE_W(BYTE_W)
) chk_i (
    .clk(clk),
    .rst(rst),
    .wr_off(wr_off),
    .en_first(lane_en[0]),
    .en_last(lane_en[LANES-1]),
    .en_all(lane_en),
    .byte_first(lane_data[BYTE_W-1:0]),
    .byte_last(lane_data[LANES*BYTE_W-1 -: BYTE_W]),
    .slots_q(slots_q)
);

// File: tb/byte_ring_writer_tb_top.sv
`timescale 1ns/1ps
module byte_ring_writer_tb_top;
    localparam int NS = 64;
    localparam int NL = 16;
    localparam int BW = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [5:0]        wr_off = '0;
    logic [NL-1:0]     lane_en = '0;
    logic [NL*BW-1:0]  lane_data = '0;
    logic [NS*BW-1:0]  slots_q;

    int unsigned n_checks = 0;
    int unsigned n_fails  = 0;
    bit          done     = 1'b0;
    logic [7:0]  model [NS];

    always #4 clk = ~clk;

    byte_ring_writer dut_i (
        .clk(clk), .rst(rst), .wr_off(wr_off),
        .lane_en(lane_en), .lane_data(lane_data), .slots_q(slots_q)
    );

    function automatic logic [NS*BW-1:0] model_vec();
        logic [NS*BW-1:0] v;
        for (int s = 0; s < NS; s++) v[s*BW +: BW] = model[s];
        return v;
    endfunction

    task automatic compare(input string req);
        logic [NS*BW-1:0] exp_v;
        exp_v = model_vec();
        n_checks++;
        if (slots_q !== exp_v) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, slots_q, exp_v);
        end
    endtask

    // drive on falling edge, model updates at the rising edge, check at next falling edge
    task automatic step(input logic r, input logic [5:0] off, input logic [NL-1:0] en,
                        input logic [NL*BW-1:0] d, input string req);
        @(negedge clk);
        rst = r; wr_off = off; lane_en = en; lane_data = d;
        @(posedge clk);
        if (r) begin
            for (int s = 0; s < NS; s++) model[s] = 8'h00;
        end else begin
            for (int i = 0; i < NL; i++)
                if (en[i]) model[(int'(off) + i) % NS] = d[i*BW +: BW];
        end
        @(negedge clk);
        compare(req);
    endtask

    function automatic logic [NL*BW-1:0] rand_data();
        logic [NL*BW-1:0] v;
        for (int w = 0; w < NL*BW/32; w++) v[w*32 +: 32] = $urandom;
        return v;
    endfunction

    initial begin
        for (int s = 0; s < NS; s++) model[s] = 8'h00;
        step(1'b1, 6'd0, '0, '0, "R1");
        step(1'b1, 6'd0, '0, '0, "R1");
        // R7: known pattern placed at known slots read from parallel output
        step(1'b0, 6'd5, 16'h0001, {{(NL-1)*BW{1'b0}}, 8'hA5}, "R2");
        step(1'b0, 6'd20, 16'h8000, {8'h3C, {(NL-1)*BW{1'b0}}}, "R2 R7");
        step(1'b0, 6'd60, 16'hFFFF, rand_data(), "R3");
        step(1'b0, 6'd63, 16'h0003, rand_data(), "R3");
        step(1'b0, 6'd30, 16'hFFFF, rand_data(), "R4");
        step(1'b0, 6'd10, 16'hA5A5, rand_data(), "R4 R5");
        step(1'b0, 6'd40, 16'h0000, rand_data(), "R6");
        step(1'b0, 6'd2, 16'h0000, {NL*BW{1'b1}}, "R6");
        step(1'b0, 6'd48, 16'h0100, rand_data(), "R5");
        step(1'b1, 6'd0, 16'hFFFF, rand_data(), "R8");
        step(1'b0, 6'd0, 16'h0000, rand_data(), "R1 R6");
        for (int k = 0; k < 400; k++) begin
            logic [NL-1:0] m;
            m = (k % 7 == 0) ? 16'hFFFF : 16'($urandom);
            step(1'b0, 6'($urandom), m, rand_data(), "R4 R5");
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end
endmodule